// File: doc/BRIEF.md
# Reset-Cause and Supply-Warning Status Register

This block is an 8-bit status/control register in the system-integrity unit of a small microcontroller. It keeps a record of what caused the most recent reset. The possible causes are the external reset pin, the watchdog and the low-voltage detector. It also shows a synchronized, live supply-warning flag and raises an interrupt request from that flag when software enables it. Two software-writable oscillator trim bits live in the same byte.

Software reaches the register through a simple select/read/write bus. Read data is returned combinationally in the cycle of the read strobe. The block also receives one-cycle pulses that mark each kind of reset event. On any such pulse the control bits go back to their reset values, and the two cause flags are updated by their own rules. The watchdog flag is cleared by writing a zero to it or by a low-voltage reset. The low-voltage flag is cleared only as a side effect of a read, so it survives watchdog and pin resets. A decoded reset-cause output gives the same answer that software would work out from the two flags.

Top module: `sis_status_reg`

## Requirements
- R1: After the power-on reset `rst_n`, with the supply comparator low, a read returns 0x60.
- R2: Bits 7 and 3 always read 0, and written values on those bits have no effect.
- R3: Trim bits 6:5 and the interrupt enable bit 0 can be read and written. Any reset event sets trim to 2'b11 and clears the enable.
- R4: A watchdog reset pulse (without a low-voltage pulse) sets bit 4 from the next cycle. A write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged.
- R5: A low-voltage reset pulse clears bit 4 and, when `lvd_en` = 1, sets bit 2 from the next cycle.
- R6: Bit 2 is not changed by pin or watchdog reset pulses, and it is not changed by writes.
- R7: A read returns bit 2 at its current value and clears it on the following clock edge. If a reset pulse arrives in the same cycle, the pulse wins and the read does not clear it.
- R8: `reset_cause` is 2'b10 when bit 2 = 1. It is 2'b01 when bit 2 = 0 and bit 4 = 1. It is 2'b00 when both bits are 0.
- R9: Bit 1 follows `supply_low_async` through two flops. A change before clock edge k shows on bit 1 after edge k+1.
- R10: `avd_irq` is high exactly when bit 0 and bit 1 are both 1.
- R11: A low-voltage reset pulse with `lvd_en` = 0 leaves bit 2 at its previous value.
- R12: `bus_rdata` is 0 whenever `bus_sel` and `bus_rd` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on initialisation |
| bus_sel | input | 1 | Register select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while selected and reading |
| lvd_rst_evt | input | 1 | One-cycle low-voltage reset event |
| wdg_rst_evt | input | 1 | One-cycle watchdog reset event |
| ext_rst_evt | input | 1 | One-cycle reset-pin event |
| lvd_en | input | 1 | Low-voltage detector enabled by configuration |
| supply_low_async | input | 1 | Asynchronous supply-below-threshold comparator |
| avd_irq | output | 1 | Supply-warning interrupt request |
| reset_cause | output | 2 | Decoded reset cause |

## Verification
A read of the register and a reset event can fall in the same cycle. The read tries to clear the low-voltage flag, while the event tries to set it or to keep it. The bench drives a read strobe together with a low-voltage pulse, and a read together with a pin pulse. It checks that the returned byte shows the state before the event, and that on the next read the flag is still set. A cycle-by-cycle reference model also judges a write that lands while the watchdog flag is being set.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int REG_W   = 8;
  localparam int B_IEN   = 0;
  localparam int B_AVD   = 1;
  localparam int B_LVDF  = 2;
  localparam int B_RSV3  = 3;
  localparam int B_WDGF  = 4;
  localparam int B_TRLO  = 5;
  localparam int B_TRHI  = 6;
  localparam int B_RSV7  = 7;
  localparam int TRIM_W  = B_TRHI - B_TRLO + 1;

  typedef enum logic [1:0] {
    CAUSE_PIN = 2'b00,
    CAUSE_WDG = 2'b01,
    CAUSE_LVD = 2'b10
  } cause_e;

  // Low-voltage flag dominates; the watchdog flag only matters without it.
  function automatic cause_e decode_cause(input logic lvd_f, input logic wdg_f);
    if (lvd_f)      return CAUSE_LVD;
    else if (wdg_f) return CAUSE_WDG;
    else            return CAUSE_PIN;
  endfunction

  function automatic logic [REG_W-1:0] pack_image(
    input logic [TRIM_W-1:0] trim,
    input logic              wdg_f,
    input logic              lvd_f,
    input logic              avd_f,
    input logic              ien
  );
    logic [REG_W-1:0] v;
    v              = '0;
    v[B_TRHI:B_TRLO] = trim;
    v[B_WDGF]      = wdg_f;
    v[B_LVDF]      = lvd_f;
    v[B_AVD]       = avd_f;
    v[B_IEN]       = ien;
    return v;
  endfunction
endpackage

// File: rtl/sis_sync.sv
module sis_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sis_evt_arb.sv
module sis_evt_arb (
  input  logic lvd_rst_evt,
  input  logic wdg_rst_evt,
  input  logic ext_rst_evt,
  output logic any_evt,
  output logic lvd_hit,
  output logic wdg_hit
);
  // The low-voltage event outranks the watchdog event when both arrive.
  assign lvd_hit = lvd_rst_evt;
  assign wdg_hit = wdg_rst_evt & ~lvd_rst_evt;
  assign any_evt = lvd_rst_evt | wdg_rst_evt | ext_rst_evt;
endmodule

// File: rtl/sis_cause_flags.sv
module sis_cause_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt,
  input  logic lvd_hit,
  input  logic wdg_hit,
  input  logic lvd_en,
  input  logic rd_acc,
  input  logic wr_acc,
  input  logic wdg_wbit,
  output logic wdg_flag,
  output logic lvd_flag,
  output logic rd_clr_evt,
  output logic wr_clr_evt
);
  // Bus side effects are suppressed in a cycle that carries a reset event.
  assign rd_clr_evt = rd_acc & ~any_evt;
  assign wr_clr_evt = wr_acc & ~any_evt & ~wdg_wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdg_flag <= 1'b0;
    end else if (lvd_hit) begin
      wdg_flag <= 1'b0;
    end else if (wdg_hit) begin
      wdg_flag <= 1'b1;
    end else if (wr_clr_evt) begin
      wdg_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvd_flag <= 1'b0;
    end else if (lvd_hit & lvd_en) begin
      lvd_flag <= 1'b1;
    end else if (rd_clr_evt) begin
      lvd_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sis_ctrl_bits.sv
module sis_ctrl_bits #(
  parameter int                      TRIM_W   = 2,
  parameter logic [TRIM_W-1:0]       TRIM_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_evt,
  input  logic              wr_acc,
  input  logic [TRIM_W-1:0] trim_wdata,
  input  logic              ien_wdata,
  output logic [TRIM_W-1:0] trim_q,
  output logic              ien_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= TRIM_RST;
      ien_q  <= 1'b0;
    end else if (any_evt) begin
      trim_q <= TRIM_RST;
      ien_q  <= 1'b0;
    end else if (wr_acc) begin
      trim_q <= trim_wdata;
      ien_q  <= ien_wdata;
    end
  end
endmodule

// File: rtl/sis_status_reg.sv
module sis_status_reg
  import sis_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [TRIM_W-1:0] TRIM_RST    = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             lvd_rst_evt,
  input  logic             wdg_rst_evt,
  input  logic             ext_rst_evt,
  input  logic             lvd_en,
  input  logic             supply_low_async,
  output logic             avd_irq,
  output logic [1:0]       reset_cause
);
  logic              rd_acc, wr_acc;
  logic              any_evt, lvd_hit, wdg_hit;
  logic              wdg_flag, lvd_flag;
  logic              rd_clr_evt, wr_clr_evt;
  logic [TRIM_W-1:0] trim_q;
  logic              ien_q;
  logic              avd_flag;
  logic              unused_wbits;

  assign rd_acc = bus_sel & bus_rd;
  assign wr_acc = bus_sel & bus_wr;
  assign unused_wbits = ^{bus_wdata[B_RSV7], bus_wdata[B_RSV3],
                          bus_wdata[B_LVDF], bus_wdata[B_AVD]};

  sis_evt_arb u_arb (
    .lvd_rst_evt (lvd_rst_evt),
    .wdg_rst_evt (wdg_rst_evt),
    .ext_rst_evt (ext_rst_evt),
    .any_evt     (any_evt),
    .lvd_hit     (lvd_hit),
    .wdg_hit     (wdg_hit)
  );

  sis_cause_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_evt    (any_evt),
    .lvd_hit    (lvd_hit),
    .wdg_hit    (wdg_hit),
    .lvd_en     (lvd_en),
    .rd_acc     (rd_acc),
    .wr_acc     (wr_acc),
    .wdg_wbit   (bus_wdata[B_WDGF]),
    .wdg_flag   (wdg_flag),
    .lvd_flag   (lvd_flag),
    .rd_clr_evt (rd_clr_evt),
    .wr_clr_evt (wr_clr_evt)
  );

  sis_ctrl_bits #(
    .TRIM_W   (TRIM_W),
    .TRIM_RST (TRIM_RST)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_evt    (any_evt),
    .wr_acc     (wr_acc),
    .trim_wdata (bus_wdata[B_TRHI:B_TRLO]),
    .ien_wdata  (bus_wdata[B_IEN]),
    .trim_q     (trim_q),
    .ien_q      (ien_q)
  );

  sis_sync #(
    .STAGES (SYNC_STAGES),
    .W      (1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (supply_low_async),
    .q     (avd_flag)
  );

  assign bus_rdata   = rd_acc ? pack_image(trim_q, wdg_flag, lvd_flag, avd_flag, ien_q)
                              : '0;
  assign avd_irq     = ien_q & avd_flag;
  assign reset_cause = decode_cause(lvd_flag, wdg_flag);
endmodule

// File: rtl/sis_status_reg_checker.sv
module sis_status_reg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       lvd_rst_evt,
  input logic       wdg_rst_evt,
  input logic       ext_rst_evt,
  input logic       lvd_en,
  input logic       avd_irq,
  input logic       wdg_flag,
  input logic       lvd_flag,
  input logic       ien_q,
  input logic [1:0] trim_q,
  input logic       rd_clr_evt
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0);

  a_r3_event_restores_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_rst_evt || wdg_rst_evt || ext_rst_evt) |=> (trim_q == 2'b11 && !ien_q));

  a_r4_wdg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_rst_evt && !lvd_rst_evt) |=> wdg_flag);

  a_r5_lvd_clears_wdg: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_rst_evt |=> !wdg_flag);

  a_r5_lvd_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_rst_evt && lvd_en) |=> lvd_flag);

  a_r6_lvd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_flag && !rd_clr_evt) |=> lvd_flag);

  a_r7_read_sees_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && lvd_flag) |-> bus_rdata[2]);

  a_r10_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !avd_irq);

  a_r11_disabled_lvd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_rst_evt && !lvd_en) |=> (lvd_flag == $past(lvd_flag)));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |-> bus_rdata == 8'h00);
endmodule

bind sis_status_reg sis_status_reg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .lvd_rst_evt (lvd_rst_evt),
  .wdg_rst_evt (wdg_rst_evt),
  .ext_rst_evt (ext_rst_evt),
  .lvd_en      (lvd_en),
  .avd_irq     (avd_irq),
  .wdg_flag    (wdg_flag),
  .lvd_flag    (lvd_flag),
  .ien_q       (ien_q),
  .trim_q      (trim_q),
  .rd_clr_evt  (rd_clr_evt)
);

// File: tb/sis_status_reg_bench.sv
`timescale 1ns/1ps
module sis_status_reg_bench;
  localparam real CLK_PERIOD = 8.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       evt_l = 1'b0, evt_w = 1'b0, evt_e = 1'b0;
  logic       lvd_en = 1'b1;
  logic       supply_low = 1'b0;
  logic       irq;
  logic [1:0] cause;

  int n_chk = 0;
  int n_fail = 0;
  bit run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sis_status_reg u_sis_status_reg (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_sel          (sel),
    .bus_rd           (rd),
    .bus_wr           (wr),
    .bus_wdata        (wdata),
    .bus_rdata        (rdata),
    .lvd_rst_evt      (evt_l),
    .wdg_rst_evt      (evt_w),
    .ext_rst_evt      (evt_e),
    .lvd_en           (lvd_en),
    .supply_low_async (supply_low),
    .avd_irq          (irq),
    .reset_cause      (cause)
  );

  // Behavioural reference state
  bit [1:0] m_trim;
  bit m_ien, m_wdg, m_lvd, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trim = 2'b11; m_ien = 0; m_wdg = 0; m_lvd = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = supply_low;
      if (evt_l || evt_w || evt_e) begin
        m_trim = 2'b11;
        m_ien  = 0;
        if (evt_l) begin
          m_wdg = 0;
          if (lvd_en) m_lvd = 1;
        end else if (evt_w) begin
          m_wdg = 1;
        end
      end else begin
        if (sel && rd) m_lvd = 0;
        if (sel && wr) begin
          m_trim = wdata[6:5];
          m_ien  = wdata[0];
          if (!wdata[4]) m_wdg = 0;
        end
      end
    end
  end

  function automatic logic [7:0] m_image();
    return {1'b0, m_trim, m_wdg, 1'b0, m_lvd, m_s2, m_ien};
  endfunction

  function automatic logic [1:0] m_cause();
    if (m_lvd) return 2'b10;
    if (m_wdg) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (run) begin
      #2;
      chk("R12 rdata vs model", rdata, (sel && rd) ? m_image() : 8'h00);
      chk("R10 irq vs model", irq, m_ien & m_s2);
      chk("R8 cause vs model", cause, m_cause());
    end
  end

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = 8'h00;
  endtask

  task automatic bus_read(input string req, input logic [7:0] exp);
    @(negedge clk); sel = 1; rd = 1;
    #1 chk(req, rdata, exp);
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) evt_e = 1; else if (which == 1) evt_w = 1; else evt_l = 1;
    @(negedge clk); evt_e = 0; evt_w = 0; evt_l = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    @(negedge clk);
    bus_read("R1 reset image", 8'h60);
    chk("R8 reset cause pin", cause, 2'b00);
    chk("R10 reset irq", irq, 1'b0);

    bus_write(8'hFF);
    bus_read("R2 R4 R6 write-ones image", 8'h61);
    bus_write(8'h20);
    bus_read("R3 trim and enable written", 8'h20);
    bus_write(8'h88);
    bus_read("R2 reserved writes ignored", 8'h00);
    bus_write(8'h20);

    // R9: comparator through two flops
    @(negedge clk); supply_low = 1;
    @(negedge clk); sel = 1; rd = 1;
    #1 chk("R9 one edge not yet visible", rdata[1], 1'b0);
    @(negedge clk);
    #1 chk("R9 visible after second edge", rdata[1], 1'b1);
    @(negedge clk); sel = 0; rd = 0;

    bus_write(8'h21);
    #1 chk("R10 irq with enable and flag", irq, 1'b1);

    pulse(1);
    bus_read("R4 R3 watchdog event image", 8'h72);
    chk("R8 cause watchdog", cause, 2'b01);
    chk("R10 irq off after event", irq, 1'b0);

    bus_write(8'h70);
    bus_read("R4 write one keeps flag", 8'h72);
    bus_write(8'h60);
    bus_read("R4 write zero clears flag", 8'h62);

    pulse(1);
    pulse(2);
    pulse(0);
    pulse(1);
    chk("R8 lvd wins over watchdog", cause, 2'b10);
    bus_read("R6 lvd flag kept over pin and watchdog", 8'h76);
    bus_read("R7 flag cleared after read", 8'h72);
    chk("R8 cause back to watchdog", cause, 2'b01);

    // R7: read and low-voltage event in the same cycle
    @(negedge clk); sel = 1; rd = 1; evt_l = 1;
    #1 chk("R7 read during event sees old state", rdata, 8'h72);
    @(negedge clk); sel = 0; rd = 0; evt_l = 0;
    bus_read("R5 R7 event beats read clear", 8'h66);
    pulse(2);
    @(negedge clk); sel = 1; rd = 1; evt_e = 1;
    @(negedge clk); sel = 0; rd = 0; evt_e = 0;
    bus_read("R7 pin event beats read clear", 8'h66);
    bus_read("R7 cleared by plain read", 8'h62);

    @(negedge clk); lvd_en = 0;
    pulse(2);
    bus_read("R11 disabled detector leaves flag clear", 8'h62);
    @(negedge clk); lvd_en = 1;
    pulse(2);
    @(negedge clk); lvd_en = 0;
    pulse(2);
    bus_read("R11 disabled detector leaves flag set", 8'h66);
    @(negedge clk); lvd_en = 1;

    @(negedge clk); supply_low = 0;
    repeat (3) @(negedge clk);
    bus_read("R9 flag follows comparator low", 8'h60);

    @(negedge clk); sel = 1; wr = 0; rd = 0;
    #1 chk("R12 selected without read", rdata, 8'h00);
    @(negedge clk); sel = 0; rd = 1;
    #1 chk("R12 read without select", rdata, 8'h00);
    @(negedge clk); rd = 0;

    // Write during a watchdog event: event wins, model judges
    @(negedge clk); sel = 1; wr = 1; wdata = 8'h01; evt_w = 1;
    @(negedge clk); sel = 0; wr = 0; wdata = 8'h00; evt_w = 0;
    bus_read("R3 R4 write loses to event", 8'h70);

    repeat (4) @(negedge clk);
    run = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule